// File: doc/BRIEF.md
# Converter Serial Output Sequencer

This block is the device side of the serial read port of a sampling converter. It steps through three phases: converting, a low-power sleep that holds a finished result, and a data-output phase that sends a 24-bit frame. The converter's modulator is replaced by a counter. A conversion finishes after a set number of `convTick` pulses. At that moment the result word is captured into a static shift register, and the end-of-conversion flag on the data line falls from 1 to 0.

A host reads the frame with a clock it drives itself (external mode), or it lets the block generate the serial clock (internal mode). The mode is taken from the serial-clock pin level when chip-select falls. If chip-select is held low out of reset, the mode is taken from the pin level at the end of reset. Raising chip-select in the middle of a frame aborts the frame and starts a new conversion. The pin's weak pull-up is modelled as a flag that clears whenever the pin is low. An abort that leaves the pin low therefore makes the next chip-select fall pick external mode.

Chip-select and the external clock are asynchronous. Both pass through synchronizers into the system clock before any edge detection. The test delay and the internal half-period are counted in system clocks.

Top module: `cnv_serial_seq`

## Requirements
- R1: While a conversion runs and chip-select is low, `sdo` is 1.
- R2: A conversion ends after CONV_TICKS `convTick` pulses. At its end `resultIn` is captured, and `sdo` reads 0 (with chip-select low) until readout starts.
- R3: The frame is 24 bits, sent most significant first. Bit 23 is 0 (the end-of-conversion flag). Bits 22 to 0 equal `resultIn[22:0]`: bit 22 is the channel, bit 21 the extended-range flag, bit 20 the sign, and bits 19 to 0 the data.
- R4: In external mode, `sdo` changes only after a falling SCK edge, so each bit can be sampled on a rising edge. Bit 23 is valid before the first rising edge.
- R5: While chip-select is high, `sdoEn` is 0 (the data line is high-impedance).
- R6: In external mode, after the 24th falling SCK edge `sdo` goes to 1 and a new conversion starts.
- R7: A chip-select rise during readout, in either mode, aborts the frame and starts a new conversion at once.
- R8: Internal mode is chosen only if the SCK pin is high, with the pull-up flag set, at the chip-select fall. With chip-select low through reset, the SCK level at the end of reset picks the mode.
- R9: In internal mode the block first drives `sckOut` low. The first rising edge comes TEST_DELAY clocks after the block starts driving. This happens after a chip-select fall during sleep, or after a conversion ends while chip-select is low. After the 24th rising edge the block releases SCK high and starts a new conversion.
- R10: In internal mode, a chip-select rise before the test delay expires returns the block to sleep, and the captured result is kept for the next readout.
- R11: An abort while the internal SCK is low clears the pull-up flag. The next chip-select fall then selects external mode, unless the pin has been seen high in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip-select, active low, asynchronous |
| sckIn | input | 1 | Resolved level of the SCK pin |
| convTick | input | 1 | One modulator step of the running conversion |
| resultIn | input | FRAME_BITS-1 | Channel, extended-range flag, sign and data, captured at conversion end |
| sdo | output | 1 | Serial data / end-of-conversion level |
| sdoEn | output | 1 | Drive enable for the data line (0 = high-impedance) |
| sckOut | output | 1 | Internally generated serial clock |
| sckOutEn | output | 1 | Drive enable for the SCK pin |

## Verification
The bench reads frames in both modes with random result words. If bits were shifted on the wrong edge, or sent in the wrong order, the frame read back would be off by one bit or reversed. It aborts frames in the middle: in external mode, and in internal mode while the clock is low. A design that kept sending after the abort would show 0 instead of the end-of-conversion 1. A design that ignored the pull-up flag would start driving SCK when external mode was due. It also drops chip-select during the test delay, then changes the input word before reading. A design that reconverted or reloaded here would return the new word instead of the held one. Two more directed cases cover mode selection out of reset and back-to-back internal frames with chip-select held low. These catch a design that samples the wrong pin level, or that never restarts the test delay after a conversion ends.

// File: rtl/cnv_serial_pkg.sv
package cnv_serial_pkg;

  typedef enum logic [2:0] {
    ST_CONV  = 3'd0,
    ST_SLEEP = 3'd1,
    ST_TEST  = 3'd2,
    ST_OUTX  = 3'd3,
    ST_OUTI  = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFrame;
    logic shiftFrame;
    logic timerClr;
    logic timerInc;
    logic bitClr;
    logic bitInc;
  } dpCmd_t;

endpackage

// File: rtl/cnv_sync.sv
module cnv_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : gStage
    if (i == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[0] <= RESET_VAL;
        else       chain[0] <= asyncIn;
    end else begin : gRest
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[i] <= RESET_VAL;
        else       chain[i] <= chain[i-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/cnv_data.sv
module cnv_data
  import cnv_serial_pkg::*;
#(
  parameter int FRAME_BITS = 24,
  parameter int TIMER_W = 5,
  parameter int BIT_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCmd_t                cmd,
  input  logic [FRAME_BITS-2:0] resultIn,
  output logic                  frameMsb,
  output logic [TIMER_W-1:0]    timerVal,
  output logic [BIT_W-1:0]      bitVal
);
  logic [FRAME_BITS-1:0] frameQ;

  // static shift register: end-of-conversion flag (0) on top of the result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               frameQ <= '0;
    else if (cmd.loadFrame)  frameQ <= {1'b0, resultIn};
    else if (cmd.shiftFrame) frameQ <= {frameQ[FRAME_BITS-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             timerVal <= '0;
    else if (cmd.timerClr) timerVal <= '0;
    else if (cmd.timerInc) timerVal <= timerVal + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           bitVal <= '0;
    else if (cmd.bitClr) bitVal <= '0;
    else if (cmd.bitInc) bitVal <= bitVal + 1'b1;
  end

  assign frameMsb = frameQ[FRAME_BITS-1];
endmodule

// File: rtl/cnv_ctrl.sv
module cnv_ctrl
  import cnv_serial_pkg::*;
#(
  parameter int FRAME_BITS = 24,
  parameter int CONV_TICKS = 16,
  parameter int TEST_DELAY = 8,
  parameter int HALF_PERIOD = 3,
  parameter int TIMER_W = 5,
  parameter int BIT_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csS,
  input  logic               sckS,
  input  logic               convTick,
  input  logic [TIMER_W-1:0] timerVal,
  input  logic [BIT_W-1:0]   bitVal,
  output dpCmd_t             cmd,
  output seqState_t          state,
  output logic               sckOut,
  output logic               sckOutEn
);
  localparam logic [TIMER_W-1:0] CONV_LAST = TIMER_W'(CONV_TICKS - 1);
  localparam logic [TIMER_W-1:0] TEST_LAST = TIMER_W'(TEST_DELAY - 1);
  localparam logic [TIMER_W-1:0] HALF_LAST = TIMER_W'(HALF_PERIOD - 1);
  localparam logic [BIT_W-1:0]   BIT_LAST  = BIT_W'(FRAME_BITS - 1);

  seqState_t stateD;
  logic csPrev, sckPrev, pullFlag, intModeQ;
  logic sckOutD, sckOutEnD;
  logic csFall, csRise, extRise, extFall;
  logic sckLevel, modeSample, modeEff;

  assign csFall     = csPrev & ~csS;
  assign csRise     = ~csPrev & csS;
  assign extRise    = sckS & ~sckPrev;
  assign extFall    = ~sckS & sckPrev;
  assign sckLevel   = sckOutEn ? sckOut : sckS;
  assign modeSample = sckLevel & pullFlag;
  assign modeEff    = csFall ? modeSample : intModeQ;

  always_comb begin
    stateD    = state;
    sckOutD   = sckOut;
    sckOutEnD = sckOutEn;
    cmd       = '0;
    unique case (state)
      ST_CONV: begin
        if (convTick) begin
          if (timerVal == CONV_LAST) begin
            cmd.loadFrame = 1'b1;
            cmd.timerClr  = 1'b1;
            stateD        = ST_SLEEP;
          end else begin
            cmd.timerInc = 1'b1;
          end
        end
      end
      ST_SLEEP: begin
        if (!csS) begin
          if (modeEff) begin
            stateD       = ST_TEST;
            sckOutEnD    = 1'b1;
            sckOutD      = 1'b0;
            cmd.timerClr = 1'b1;
          end else if (extRise) begin
            stateD     = ST_OUTX;
            cmd.bitClr = 1'b1;
          end
        end
      end
      ST_TEST: begin
        if (csS) begin
          stateD    = ST_SLEEP;
          sckOutEnD = 1'b0;
        end else if (timerVal == TEST_LAST) begin
          stateD       = ST_OUTI;
          sckOutD      = 1'b1;
          cmd.timerClr = 1'b1;
          cmd.bitClr   = 1'b1;
        end else begin
          cmd.timerInc = 1'b1;
        end
      end
      ST_OUTX: begin
        if (csS) begin
          stateD       = ST_CONV;
          cmd.timerClr = 1'b1;
        end else if (extFall) begin
          if (bitVal == BIT_LAST) begin
            stateD       = ST_CONV;
            cmd.timerClr = 1'b1;
          end else begin
            cmd.shiftFrame = 1'b1;
            cmd.bitInc     = 1'b1;
          end
        end
      end
      ST_OUTI: begin
        if (csS) begin
          stateD       = ST_CONV;
          sckOutEnD    = 1'b0;
          cmd.timerClr = 1'b1;
        end else if (timerVal == HALF_LAST) begin
          cmd.timerClr = 1'b1;
          if (sckOut) begin
            if (bitVal == BIT_LAST) begin
              stateD    = ST_CONV;
              sckOutEnD = 1'b0;
            end else begin
              sckOutD        = 1'b0;
              cmd.shiftFrame = 1'b1;
            end
          end else begin
            sckOutD    = 1'b1;
            cmd.bitInc = 1'b1;
          end
        end else begin
          cmd.timerInc = 1'b1;
        end
      end
      default: stateD = ST_CONV;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_CONV;
      csPrev   <= 1'b1;
      sckPrev  <= 1'b1;
      pullFlag <= 1'b1;
      intModeQ <= 1'b1;
      sckOut   <= 1'b1;
      sckOutEn <= 1'b0;
    end else begin
      state    <= stateD;
      csPrev   <= csS;
      sckPrev  <= sckS;
      pullFlag <= sckLevel;
      sckOut   <= sckOutD;
      sckOutEn <= sckOutEnD;
      if (csFall) intModeQ <= modeSample;
    end
  end

  logic unusedRise;
  assign unusedRise = csRise;
endmodule

// File: rtl/cnv_serial_seq.sv
module cnv_serial_seq
  import cnv_serial_pkg::*;
#(
  parameter int FRAME_BITS = 24,
  parameter int CONV_TICKS = 16,
  parameter int TEST_DELAY = 8,
  parameter int HALF_PERIOD = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csN,
  input  logic                  sckIn,
  input  logic                  convTick,
  input  logic [FRAME_BITS-2:0] resultIn,
  output logic                  sdo,
  output logic                  sdoEn,
  output logic                  sckOut,
  output logic                  sckOutEn
);
  localparam int MAX_CNT = (CONV_TICKS > TEST_DELAY)
                         ? ((CONV_TICKS > HALF_PERIOD) ? CONV_TICKS : HALF_PERIOD)
                         : ((TEST_DELAY > HALF_PERIOD) ? TEST_DELAY : HALF_PERIOD);
  localparam int TIMER_W = $clog2(MAX_CNT + 1);
  localparam int BIT_W   = $clog2(FRAME_BITS);

  logic csHighW, sckSyncW, frameMsbW;
  logic [TIMER_W-1:0] timerW;
  logic [BIT_W-1:0]   bitW;
  dpCmd_t    cmdW;
  seqState_t stateW;

  cnv_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uCsSync (
    .clk(clk), .rstN(rstN), .asyncIn(csN), .syncOut(csHighW));

  cnv_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uSckSync (
    .clk(clk), .rstN(rstN), .asyncIn(sckIn), .syncOut(sckSyncW));

  cnv_ctrl #(
    .FRAME_BITS(FRAME_BITS), .CONV_TICKS(CONV_TICKS), .TEST_DELAY(TEST_DELAY),
    .HALF_PERIOD(HALF_PERIOD), .TIMER_W(TIMER_W), .BIT_W(BIT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .csS(csHighW), .sckS(sckSyncW), .convTick(convTick),
    .timerVal(timerW), .bitVal(bitW), .cmd(cmdW), .state(stateW),
    .sckOut(sckOut), .sckOutEn(sckOutEn));

  cnv_data #(.FRAME_BITS(FRAME_BITS), .TIMER_W(TIMER_W), .BIT_W(BIT_W)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmdW), .resultIn(resultIn),
    .frameMsb(frameMsbW), .timerVal(timerW), .bitVal(bitW));

  assign sdoEn = ~csHighW;

  always_comb begin
    unique case (stateW)
      ST_CONV:          sdo = 1'b1;
      ST_OUTX, ST_OUTI: sdo = frameMsbW;
      default:          sdo = 1'b0;
    endcase
  end
endmodule

// File: rtl/cnv_serial_chk.sv
module cnv_serial_chk
  import cnv_serial_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input seqState_t state,
  input logic      csHigh,
  input logic      sdo,
  input logic      sdoEn,
  input logic      sckOut,
  input logic      sckOutEn
);
  a_r1_conv_eoc: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && sdoEn) |-> sdo);

  a_r2_sleep_eoc: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SLEEP || state == ST_TEST) && sdoEn) |-> !sdo);

  a_r7_abort: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_OUTX || state == ST_OUTI) && csHigh) |=> state == ST_CONV);

  a_r9_test_low: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TEST) |-> (sckOutEn && !sckOut));

  a_r9_drive_scope: assert property (@(posedge clk) disable iff (!rstN)
    sckOutEn |-> (state == ST_TEST || state == ST_OUTI));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TEST && csHigh) |=> state == ST_SLEEP);

  a_r6_ext_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OUTX) |=> (state == ST_OUTX || state == ST_CONV));
endmodule

bind cnv_serial_seq cnv_serial_chk chk (
  .clk(clk), .rstN(rstN), .state(stateW), .csHigh(csHighW),
  .sdo(sdo), .sdoEn(sdoEn), .sckOut(sckOut), .sckOutEn(sckOutEn));

// File: tb/cnv_serial_seq_test.sv
module cnv_serial_seq_test;
  localparam int FB = 24;
  localparam int TD = 8;
  localparam int HP = 3;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, extLevel = 1'b1, convTick = 1'b0;
  logic [FB-2:0] resultIn = '0;
  logic sdo, sdoEn, sckOut, sckOutEn, sckPin;

  int checks = 0, fails = 0, cyc = 0;
  int rises = 0, enCyc = 0, riseCyc = 0;
  bit prevHi = 0, prevEn = 0, done = 0;
  logic [FB-1:0] intBits = '0;

  always #5 clk = ~clk;

  assign sckPin = sckOutEn ? sckOut : extLevel;

  cnv_serial_seq #(.FRAME_BITS(FB), .CONV_TICKS(16), .TEST_DELAY(TD),
                   .HALF_PERIOD(HP), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sckIn(sckPin), .convTick(convTick),
    .resultIn(resultIn), .sdo(sdo), .sdoEn(sdoEn), .sckOut(sckOut), .sckOutEn(sckOutEn));

  function automatic logic [FB-1:0] expFrame(input logic [FB-2:0] r);
    return {1'b0, r};
  endfunction

  task automatic check(input string tag, input logic [FB-1:0] got, input logic [FB-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // modulator steps
  always @(negedge clk) convTick <= 1'($urandom & 1);

  // internal-clock monitor: capture sdo at each rising sckOut
  always @(negedge clk) begin
    cyc++;
    if (sckOutEn && !prevEn) enCyc = cyc;
    if (sckOutEn && sckOut && !prevHi && rises < FB) begin
      if (rises == 0) riseCyc = cyc;
      intBits[FB-1-rises] = sdo;
      rises++;
    end
    prevHi = sckOutEn && sckOut;
    prevEn = sckOutEn;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d expected <150000 cycles", cyc);
      summary();
    end
  end

  task automatic readExt(output logic [FB-1:0] got);
    for (int i = FB - 1; i >= 0; i--) begin
      got[i] = sdo;
      extLevel = 1'b1; waitCyc(6);
      extLevel = 1'b0; waitCyc(6);
    end
  endtask

  task automatic waitInt(input string tag);
    int t = 0;
    while (rises < FB && t < 3000) begin waitCyc(1); t++; end
    check({tag, " frame complete"}, 24'(rises), 24'(FB));
  endtask

  logic [FB-1:0] got;
  logic [FB-2:0] r, rA, rB;

  initial begin
    void'($urandom(32'h5EED_C0DE));
    waitCyc(4); rstN = 1'b1; waitCyc(3);
    check("R5 reset sdoEn", 24'(sdoEn), 24'd0);
    check("R9 reset sckOutEn", 24'(sckOutEn), 24'd0);

    // external read, chip-select low during conversion
    r = 23'($urandom); resultIn = r; extLevel = 1'b0;
    csN = 1'b0; waitCyc(5);
    check("R1 eoc high in conversion", 24'(sdo), 24'd1);
    waitCyc(120);
    check("R2 eoc low in sleep", 24'(sdo), 24'd0);
    check("R8 external selected", 24'(sckOutEn), 24'd0);
    readExt(got);
    check("R3 R4 external frame", got, expFrame(r));
    check("R6 sdo high after frame", 24'(sdo), 24'd1);
    csN = 1'b1; waitCyc(4);
    check("R5 hi-z when deselected", 24'(sdoEn), 24'd0);

    // external abort
    r = 23'($urandom); resultIn = r; waitCyc(120);
    csN = 1'b0; waitCyc(4);
    for (int i = 0; i < 5; i++) begin
      extLevel = 1'b1; waitCyc(6); extLevel = 1'b0; waitCyc(6);
    end
    csN = 1'b1; waitCyc(4); csN = 1'b0; waitCyc(4);
    check("R7 external abort restarts conversion", 24'(sdo), 24'd1);
    rA = 23'($urandom); resultIn = rA; waitCyc(120);
    readExt(got);
    check("R7 frame after abort", got, expFrame(rA));

    // random internal frames
    for (int k = 0; k < 4; k++) begin
      csN = 1'b1; extLevel = 1'b1;
      r = 23'($urandom); resultIn = r;
      waitCyc(120); rises = 0;
      csN = 1'b0; waitCyc(5);
      check("R9 sck driven low first", {22'd0, sckOutEn, sckOut}, 24'b10);
      waitInt("R9");
      check("R3 R9 internal frame", intBits, expFrame(r));
      check("R9 first rise after test delay", 24'(riseCyc - enCyc), 24'(TD));
      waitCyc(HP + 3);
      check("R9 new conversion after frame", {22'd0, sdo, sckOutEn}, 24'b10);
    end

    // chip-select held low: next frame follows conversion end
    rB = 23'($urandom); resultIn = rB; rises = 0;
    waitInt("R9 held");
    check("R9 frame after eoc fall", intBits, expFrame(rB));

    // release during test delay keeps result
    waitCyc(HP + 3);
    csN = 1'b1; rA = 23'($urandom); resultIn = rA; waitCyc(120);
    rB = 23'($urandom); resultIn = rB;
    csN = 1'b0; waitCyc(4);
    csN = 1'b1; waitCyc(8);
    rises = 0; csN = 1'b0; waitCyc(3);
    check("R10 still asleep", 24'(sdo), 24'd0);
    waitInt("R10");
    check("R10 held result", intBits, expFrame(rA));

    // abort while internal sck is low, no pull-up on pin
    csN = 1'b1; waitCyc(120); rises = 0; csN = 1'b0;
    begin
      int t = 0;
      while (!(rises == 5 && sckOutEn && !sckOut) && t < 2000) begin waitCyc(1); t++; end
    end
    extLevel = 1'b0; csN = 1'b1;
    r = 23'($urandom); resultIn = r; waitCyc(120);
    csN = 1'b0; waitCyc(3 * TD + 10);
    check("R11 external after low abort", {22'd0, sckOutEn, sdo}, 24'b00);
    readExt(got);
    check("R11 external frame", got, expFrame(r));
    csN = 1'b1; extLevel = 1'b1; waitCyc(120);
    csN = 1'b0; waitCyc(5);
    check("R11 internal again once pin high", 24'(sckOutEn), 24'd1);
    csN = 1'b1; waitCyc(10);

    // reset with chip-select tied low, sck low
    rstN = 1'b0; csN = 1'b0; extLevel = 1'b0;
    r = 23'($urandom); resultIn = r; waitCyc(3); rstN = 1'b1;
    waitCyc(150);
    check("R8 reset-end external", {22'd0, sckOutEn, sdo}, 24'b00);
    readExt(got);
    check("R8 frame after reset", got, expFrame(r));

    // reset with sck high selects internal
    rstN = 1'b0; extLevel = 1'b1; r = 23'($urandom); resultIn = r;
    waitCyc(3); rises = 0; rstN = 1'b1;
    waitInt("R8 internal");
    check("R8 internal frame after reset", intBits, expFrame(r));

    summary();
  end
endmodule